// File: doc/BRIEF.md
# Carry-Save Running Accumulator

This block keeps a running total of a stream of unsigned operands, accepting one operand per clock. The total is never held as a single binary word. Instead it lives in two registers, a partial-sum vector and a shifted-carry vector, and the value it stands for is their arithmetic sum. Each accepted operand is merged with the two stored vectors by a row of independent full adders (a 3:2 compressor), so the accumulate path is one full-adder deep whatever the width.

A carry-propagate adder is used only when the total is read. A read request resolves the redundant pair into binary and presents it one cycle later with a valid strobe. A clear input returns the total to zero. The accumulator is wider than the operand so that long runs of additions fit, and any growth beyond its width wraps.

Top module: `csa_accum`

## Requirements
- R1: Every cycle with addValid high and clear low increases the represented total by addData, zero-extended to ACC_W bits, modulo 2^ACC_W.
- R2: In a cycle with neither addValid nor clear high, the represented total does not change, so consecutive reads return the same value.
- R3: readValid is high in the cycle after each cycle in which readReq was high, and low in every other cycle.
- R4: clear sets the total to zero at the next clock edge and wins over an add in the same cycle.
- R5: readData, while readValid is high, equals the total after the update of the request cycle, so an add or clear in that same cycle is included.
- R6: Growth beyond ACC_W bits is discarded: the total wraps modulo 2^ACC_W with no error indication.
- R7: After reset readValid is low, readData is zero and the represented total is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous zeroing of the total |
| addValid | input | 1 | Operand on addData is accepted this cycle |
| addData | input | IN_W | Unsigned operand |
| readReq | input | 1 | Request a resolved binary total |
| readValid | output | 1 | readData holds a resolved total this cycle |
| readData | output | ACC_W | Resolved binary total |

## Verification
The bench sweeps every operand value of a small configuration, reading after each add and also with the read in the same cycle as the add, which exposes a design that resolves the pair before rather than after its update (it returns a total one operand short). Long runs of large operands drive the total through many wraps; a carry vector whose top bit leaks into the resolved sum, or a resolve adder one bit too narrow, shows up as a wrong total after the first overflow. Clear arriving together with an add or a read checks priority: a design that lets the add through returns the operand instead of zero. Idle reads repeated back to back catch a read path that disturbs the stored pair.

// File: rtl/csaacc_pkg.sv
package csaacc_pkg;

  // Strobes from control to datapath, one cycle's worth of decisions.
  typedef struct packed {
    logic clr;  // zero both stored vectors
    logic acc;  // fold the operand into the pair
    logic rd;   // capture a resolved total
  } csaStrobe_t;

endpackage

// File: rtl/csaacc_compress.sv
// Row of independent full adders: three vectors in, sum and majority out.
module csaacc_compress #(
  parameter int W = 16
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] majOut
);

  for (genvar bitIdx = 0; bitIdx < W; bitIdx++) begin : g_fa
    assign sumOut[bitIdx] = inA[bitIdx] ^ inB[bitIdx] ^ inC[bitIdx];
    assign majOut[bitIdx] = (inA[bitIdx] & inB[bitIdx])
                          | (inA[bitIdx] & inC[bitIdx])
                          | (inB[bitIdx] & inC[bitIdx]);
  end

endmodule

// File: rtl/csaacc_ctrl.sv
// Decodes the request pins into datapath strobes and times the read strobe.
module csaacc_ctrl
  import csaacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       addValid,
  input  logic       readReq,
  output csaStrobe_t strobe,
  output logic       readValid
);

  always_comb begin
    strobe.clr = clear;
    strobe.acc = addValid & ~clear;   // clear has priority
    strobe.rd  = readReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readValid <= 1'b0;
    else       readValid <= readReq;
  end

endmodule

// File: rtl/csaacc_datapath.sv
// Redundant-form storage plus the resolve adder used only on reads.
module csaacc_datapath
  import csaacc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  csaStrobe_t       strobe,
  input  logic [IN_W-1:0]  addData,
  output logic [ACC_W-1:0] readData,
  output logic [ACC_W-1:0] sumVec,
  output logic [ACC_W-1:0] carVec
);

  localparam int PAD_W = ACC_W - IN_W;

  logic [ACC_W-1:0] opExt;
  logic [ACC_W-1:0] csaSum;
  logic [ACC_W-1:0] csaMaj;
  logic [ACC_W-1:0] nextSum;
  logic [ACC_W-1:0] nextCar;

  assign opExt = {{PAD_W{1'b0}}, addData};

  csaacc_compress #(.W(ACC_W)) u_compress (
    .inA   (sumVec),
    .inB   (carVec),
    .inC   (opExt),
    .sumOut(csaSum),
    .majOut(csaMaj)
  );

  // Carry weight is absorbed by shifting; the top majority bit falls off.
  always_comb begin
    if (strobe.clr) begin
      nextSum = '0;
      nextCar = '0;
    end else if (strobe.acc) begin
      nextSum = csaSum;
      nextCar = {csaMaj[ACC_W-2:0], 1'b0};
    end else begin
      nextSum = sumVec;
      nextCar = carVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumVec <= '0;
      carVec <= '0;
    end else begin
      sumVec <= nextSum;
      carVec <= nextCar;
    end
  end

  // Single carry-propagate adder, off the accumulate loop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          readData <= '0;
    else if (strobe.rd) readData <= nextSum + nextCar;
  end

endmodule

// File: rtl/csa_accum.sv
module csa_accum
  import csaacc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             addValid,
  input  logic [IN_W-1:0]  addData,
  input  logic             readReq,
  output logic             readValid,
  output logic [ACC_W-1:0] readData
);

  csaStrobe_t       strobe;
  logic [ACC_W-1:0] sumVec;
  logic [ACC_W-1:0] carVec;

  csaacc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .addValid (addValid),
    .readReq  (readReq),
    .strobe   (strobe),
    .readValid(readValid)
  );

  csaacc_datapath #(.IN_W(IN_W), .ACC_W(ACC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .addData (addData),
    .readData(readData),
    .sumVec  (sumVec),
    .carVec  (carVec)
  );

endmodule

// File: rtl/csaacc_chk.sv
module csaacc_chk #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             addValid,
  input logic [IN_W-1:0]  addData,
  input logic             readReq,
  input logic             readValid,
  input logic [ACC_W-1:0] readData,
  input logic [ACC_W-1:0] sumVec,
  input logic [ACC_W-1:0] carVec
);

  localparam int PAD_W = ACC_W - IN_W;

  logic [ACC_W-1:0] total;
  logic [ACC_W-1:0] opExt;
  assign total = sumVec + carVec;
  assign opExt = {{PAD_W{1'b0}}, addData};

  AST_ADD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (addValid && !clear) |=> (total == $past(total) + $past(opExt))) else $error("add");  // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!addValid && !clear) |=> ($stable(sumVec) && $stable(carVec))) else $error("hold");  // R2

  AST_RD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    readReq |=> readValid) else $error("rd rise");  // R3

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |=> !readValid) else $error("rd quiet");  // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (sumVec == '0 && carVec == '0)) else $error("clear");  // R4

  AST_READ_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> (readData == total)) else $error("read total");  // R5

endmodule

bind csa_accum csaacc_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clear    (clear),
  .addValid (addValid),
  .addData  (addData),
  .readReq  (readReq),
  .readValid(readValid),
  .readData (readData),
  .sumVec   (sumVec),
  .carVec   (carVec)
);

// File: tb/tb_csa_accum.sv
module tb_csa_accum;

  localparam int IN_W  = 8;
  localparam int ACC_W = 10;
  localparam int MODV  = 1 << ACC_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clear = 1'b0;
  logic             addValid = 1'b0;
  logic [IN_W-1:0]  addData = '0;
  logic             readReq = 1'b0;
  logic             readValid;
  logic [ACC_W-1:0] readData;

  int checks = 0;
  int errors = 0;
  int refTotal = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  csa_accum #(.IN_W(IN_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rstN(rstN), .clear(clear), .addValid(addValid),
    .addData(addData), .readReq(readReq),
    .readValid(readValid), .readData(readData)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle from a negedge; sample after the edge.
  task automatic cyc(input logic c, input logic a, input int d,
                     input logic r, input string tag);
    clear = c; addValid = a; addData = IN_W'(d); readReq = r;
    @(posedge clk); #2;
    if (c)      refTotal = 0;
    else if (a) refTotal = (refTotal + d) % MODV;
    check(int'(readValid), int'(r), "R3");
    if (r) check(int'(readData), refTotal, tag);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state at the ports
    check(int'(readValid), 0, "R7");
    check(int'(readData), 0, "R7");
    rstN = 1'b1;
    @(negedge clk);
    cyc(1'b0, 1'b0, 0, 1'b1, "R7");

    // R1: every operand, reads in separate cycles
    for (int v = 0; v < 256; v++) begin
      cyc(1'b0, 1'b1, v, 1'b0, "R1");
      if (v % 4 == 3) cyc(1'b0, 1'b0, 0, 1'b1, "R1");
    end

    // R2: idle reads back to back return the same total
    cyc(1'b0, 1'b0, 0, 1'b1, "R2");
    cyc(1'b0, 1'b0, 0, 1'b0, "R2");
    cyc(1'b0, 1'b0, 0, 1'b1, "R2");

    // R4: clear with an add in the same cycle, then read
    cyc(1'b1, 1'b1, 200, 1'b0, "R4");
    cyc(1'b0, 1'b0, 0, 1'b1, "R4");
    // R4: clear and read together returns zero
    cyc(1'b0, 1'b1, 77, 1'b0, "R4");
    cyc(1'b1, 1'b0, 0, 1'b1, "R4");

    // R5: add and read in the same cycle over every operand
    for (int v = 255; v >= 0; v--) cyc(1'b0, 1'b1, v, 1'b1, "R5");

    // R6: large operands wrap the total many times
    cyc(1'b1, 1'b0, 0, 1'b0, "R6");
    for (int k = 0; k < 40; k++) cyc(1'b0, 1'b1, 255, (k % 3 == 2), "R6");
    cyc(1'b0, 1'b0, 0, 1'b1, "R6");
    for (int k = 0; k < 30; k++) cyc(1'b0, 1'b1, 129 + k, 1'b1, "R6");

    doneFlag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule